// File: doc/BRIEF.md
# I2C EEPROM Transaction Sequencer

This block sits between a request source and an I2C byte-level engine. It accepts one request at a time: a write, a read or a presence probe. Each request names a 7-bit device address, a memory address of zero up to `ADDR_BYTES` bytes, and a transfer length. The block turns the request into an ordered stream of engine commands: START, STOP, send a byte, or receive a byte with a chosen acknowledge level. Each command is handed over with a valid/ready handshake, and the engine answers every command with exactly one response pulse.

Write payload bytes come in on a byte stream. Received bytes go out on a byte stream. When the transaction ends, the block raises `done` for one cycle. In that cycle it presents the outcome: whether the device address was refused, whether an address byte was refused, how many payload bytes were refused (saturating at 255), and whether a probe found the device. A read that carries an address first sets the device's pointer. It then closes the bus with a full STOP and opens a fresh START before the read phase. A repeated START is not used. An optional fold-in mode moves memory-address bits that lie above the address length into the low bits of the device address, under a parameter mask.

Top module: `eeprom_xact_seq`

## Requirements
- R1: A write request issues START, then a send-byte of `{chip,0}`. Command codes are 0 START, 1 STOP, 2 send byte, 3 receive byte.
- R2: If the device-address byte of the write or address phase is NACKed, the block issues STOP and ends with `st_chip_nack` set and the other outcome fields clear.
- R3: Exactly `alen` memory-address bytes are sent, most significant first, after the device-address byte is ACKed.
- R4: A NACK on any memory-address byte stops further address and data bytes, issues STOP and ends with `st_addr_nack` set.
- R5: A read with `alen` above zero follows the address bytes with STOP, then START, then a send-byte of `{chip,1}`.
- R6: A read with `alen` of zero skips the `{chip,0}` byte and the address bytes entirely: START is followed directly by `{chip,1}`.
- R7: A read issues `len` receive-byte commands. `cmd_nack` is 0 on all of them except the last, where it is 1. Each received byte leaves on `rd_data` in order. STOP ends the read.
- R8: During a write, a NACKed payload byte does not stop the transfer. All `len` bytes are sent, and `st_fail_cnt` counts the NACKs, saturating at 255.
- R9: With `req_ovf` set, `(addr >> 8*alen) & OVF_MASK` is ORed into the device address. This applies to every device-address byte of the request.
- R10: A probe issues START, `{chip,1}`, STOP. `st_present` is 1 only if that byte was ACKed.
- R11: A read with `len` of zero performs the address phase and the `{chip,1}` byte, receives nothing, and ends with STOP.
- R12: After reset, and between requests, `req_ready` is high and no command is issued. `done` lasts exactly one cycle. A pending command stays stable until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request accepted |
| req_op | input | 2 | 0 write, 1 read, 2 probe |
| req_chip | input | 7 | Device address |
| req_addr | input | 8*ADDR_BYTES | Memory address |
| req_alen | input | $clog2(ADDR_BYTES+1) | Address bytes to send |
| req_len | input | LEN_W | Payload byte count |
| req_ovf | input | 1 | Fold high address bits into device address |
| wr_valid | input | 1 | Write byte available |
| wr_ready | output | 1 | Write byte consumed |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte available |
| rd_ready | input | 1 | Read byte taken |
| rd_data | output | 8 | Read byte |
| cmd_valid | output | 1 | Command offered to engine |
| cmd_ready | input | 1 | Engine accepts command |
| cmd_code | output | 2 | 0 START, 1 STOP, 2 send byte, 3 receive byte |
| cmd_byte | output | 8 | Byte to send (0 otherwise) |
| cmd_nack | output | 1 | Acknowledge level for receive byte (1 = NACK) |
| rsp_valid | input | 1 | Engine finished the last command |
| rsp_nack | input | 1 | Sent byte was NACKed |
| rsp_byte | input | 8 | Received byte |
| done | output | 1 | One-cycle completion strobe |
| st_chip_nack | output | 1 | Device address refused |
| st_addr_nack | output | 1 | Memory address byte refused |
| st_fail_cnt | output | 8 | Refused write payload bytes, saturating |
| st_present | output | 1 | Probe saw an ACK |

## Verification
The assertions check the per-cycle contracts on every cycle. A command offered and not yet accepted stays stable, and so does an unread received byte. The done strobe never lasts two cycles. Both error flags are never set together. No command appears while idle, and a non-write never reports payload failures. The command ordering can only be shown by the directed scenarios: the byte order of the address, the STOP/START pair before reads, the acknowledge level on the final received byte, the fold-in of high address bits, the continuation after payload NACKs and the saturation of their count. Each scenario logs every command the engine receives and compares the log against a sequence built from the request.

// File: rtl/eeprom_xact_seq.sv
module eeprom_xact_seq #(
  parameter int ADDR_BYTES = 4,
  parameter int LEN_W = 16,
  parameter logic [6:0] OVF_MASK = 7'h07,
  localparam int AW = 8 * ADDR_BYTES,
  localparam int AB_W = $clog2(ADDR_BYTES + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [1:0]      req_op,
  input  logic [6:0]      req_chip,
  input  logic [AW-1:0]   req_addr,
  input  logic [AB_W-1:0] req_alen,
  input  logic [LEN_W-1:0] req_len,
  input  logic            req_ovf,
  input  logic            wr_valid,
  output logic            wr_ready,
  input  logic [7:0]      wr_data,
  output logic            rd_valid,
  input  logic            rd_ready,
  output logic [7:0]      rd_data,
  output logic            cmd_valid,
  input  logic            cmd_ready,
  output logic [1:0]      cmd_code,
  output logic [7:0]      cmd_byte,
  output logic            cmd_nack,
  input  logic            rsp_valid,
  input  logic            rsp_nack,
  input  logic [7:0]      rsp_byte,
  output logic            done,
  output logic            st_chip_nack,
  output logic            st_addr_nack,
  output logic [7:0]      st_fail_cnt,
  output logic            st_present
);
  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_PROBE = 2'd2;
  localparam logic [1:0] C_START = 2'd0, C_STOP = 2'd1, C_SEND = 2'd2, C_RECV = 2'd3;

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_WCHIP, S_ADDR, S_MSTOP, S_RCHIP, S_RDATA, S_WDATA, S_STOP
  } st_t;

  st_t              st;
  logic             wait_q, rphase_q;
  logic [1:0]       op_q;
  logic [6:0]       chip_q;
  logic [AW-1:0]    addr_q;
  logic [AB_W-1:0]  alen_q, acnt_q;
  logic [LEN_W-1:0] left_q;

  logic [AB_W-1:0] asel;
  logic [7:0]      addr_byte;
  logic [6:0]      chip_fold;
  logic            fire, got, last;

  assign asel      = alen_q - AB_W'(1) - acnt_q;
  assign addr_byte = 8'(addr_q >> {asel, 3'b000});
  assign chip_fold = req_chip | (req_ovf ? (7'(req_addr >> {req_alen, 3'b000}) & OVF_MASK) : 7'd0);
  assign last      = (left_q == LEN_W'(1));

  assign req_ready = (st == S_IDLE);
  assign cmd_valid = (st != S_IDLE) && !wait_q && (st != S_WDATA || wr_valid) && (st != S_RDATA || !rd_valid);
  assign wr_ready  = (st == S_WDATA) && !wait_q && cmd_ready;
  assign fire      = cmd_valid && cmd_ready;
  assign got       = wait_q && rsp_valid;

  always_comb begin
    cmd_code = C_START;
    cmd_byte = 8'd0;
    cmd_nack = 1'b0;
    case (st)
      S_MSTOP, S_STOP: cmd_code = C_STOP;
      S_WCHIP: begin cmd_code = C_SEND; cmd_byte = {chip_q, 1'b0}; end
      S_RCHIP: begin cmd_code = C_SEND; cmd_byte = {chip_q, 1'b1}; end
      S_ADDR:  begin cmd_code = C_SEND; cmd_byte = addr_byte; end
      S_WDATA: begin cmd_code = C_SEND; cmd_byte = wr_data; end
      S_RDATA: begin cmd_code = C_RECV; cmd_nack = last; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; wait_q <= 1'b0; rphase_q <= 1'b0; op_q <= OP_WR;
      chip_q <= '0; addr_q <= '0; alen_q <= '0; acnt_q <= '0; left_q <= '0;
      rd_valid <= 1'b0; rd_data <= '0; done <= 1'b0;
      st_chip_nack <= 1'b0; st_addr_nack <= 1'b0; st_fail_cnt <= '0; st_present <= 1'b0;
    end else begin
      done <= 1'b0;
      if (fire) wait_q <= 1'b1;
      if (got) wait_q <= 1'b0;
      if (rd_valid && rd_ready) begin
        rd_valid <= 1'b0;
        left_q <= left_q - LEN_W'(1);
        if (last) st <= S_STOP;
      end
      case (st)
        S_IDLE: if (req_valid) begin
          st <= S_START; op_q <= req_op; chip_q <= chip_fold; addr_q <= req_addr;
          alen_q <= req_alen; left_q <= req_len; acnt_q <= '0; rphase_q <= 1'b0;
          st_chip_nack <= 1'b0; st_addr_nack <= 1'b0; st_fail_cnt <= '0; st_present <= 1'b0;
        end
        S_START: if (got)
          st <= (op_q != OP_WR && (op_q == OP_PROBE || alen_q == '0 || rphase_q)) ? S_RCHIP : S_WCHIP;
        S_WCHIP: if (got) begin
          if (rsp_nack) begin st_chip_nack <= 1'b1; st <= S_STOP; end
          else if (alen_q != '0) st <= S_ADDR;
          else st <= (left_q == '0) ? S_STOP : S_WDATA;
        end
        S_ADDR: if (got) begin
          if (rsp_nack) begin st_addr_nack <= 1'b1; st <= S_STOP; end
          else if (acnt_q == alen_q - AB_W'(1)) begin
            if (op_q == OP_RD) st <= S_MSTOP;
            else st <= (left_q == '0) ? S_STOP : S_WDATA;
          end else acnt_q <= acnt_q + AB_W'(1);
        end
        S_MSTOP: if (got) begin rphase_q <= 1'b1; st <= S_START; end
        S_RCHIP: if (got) begin
          if (op_q == OP_PROBE) begin st_present <= !rsp_nack; st <= S_STOP; end
          else st <= (left_q == '0) ? S_STOP : S_RDATA;
        end
        S_RDATA: if (got) begin rd_valid <= 1'b1; rd_data <= rsp_byte; end
        S_WDATA: if (got) begin
          if (rsp_nack && st_fail_cnt != 8'hFF) st_fail_cnt <= st_fail_cnt + 8'd1;
          left_q <= left_q - LEN_W'(1);
          if (last) st <= S_STOP;
        end
        S_STOP: if (got) begin done <= 1'b1; st <= S_IDLE; end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r12_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_code) && $stable(cmd_byte) && $stable(cmd_nack));
  a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n) req_ready |-> !cmd_valid);
  a_r2_single_error: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(st_chip_nack && st_addr_nack));
  a_r7_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_data));
  a_r8_fail_write_only: assert property (@(posedge clk) disable iff (!rst_n)
    done && op_q != OP_WR |-> st_fail_cnt == 8'd0);
endmodule

// File: tb/eeprom_xact_seq_tb.sv
module eeprom_xact_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  logic clk = 1'b0, rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic req_valid = 0, req_ready, req_ovf = 0;
  logic [1:0] req_op = 0;
  logic [6:0] req_chip = 0;
  logic [31:0] req_addr = 0;
  logic [2:0] req_alen = 0;
  logic [15:0] req_len = 0;
  logic wr_ready, rd_valid, cmd_valid, cmd_nack, done;
  logic [7:0] wr_data, rd_data, cmd_byte, rsp_byte, st_fail_cnt;
  logic [1:0] cmd_code;
  logic rsp_valid, rsp_nack, st_chip_nack, st_addr_nack, st_present;

  eeprom_xact_seq dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_chip(req_chip), .req_addr(req_addr), .req_alen(req_alen), .req_len(req_len), .req_ovf(req_ovf),
    .wr_valid(1'b1), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(1'b1), .rd_data(rd_data),
    .cmd_valid(cmd_valid), .cmd_ready(1'b1), .cmd_code(cmd_code), .cmd_byte(cmd_byte), .cmd_nack(cmd_nack),
    .rsp_valid(rsp_valid), .rsp_nack(rsp_nack), .rsp_byte(rsp_byte),
    .done(done), .st_chip_nack(st_chip_nack), .st_addr_nack(st_addr_nack),
    .st_fail_cnt(st_fail_cnt), .st_present(st_present));

  int total = 0, bad = 0;
  logic clr = 0;
  int n1 = -1, n2 = -1, nfrom = 100000;
  int lidx, wptr, rcnt;
  logic [10:0] lg [0:511];
  logic [7:0] rbuf [0:15];
  logic [10:0] ex [0:63];
  int ne;
  logic dseen, c_chip, c_addr, c_pres;
  logic [7:0] c_fail;

  assign wr_data = 8'h30 + wptr[7:0];

  always @(posedge clk) begin
    rsp_valid <= 1'b0;
    if (clr || !rst_n) begin lidx <= 0; wptr <= 0; rcnt <= 0; dseen <= 0; end
    else begin
      if (cmd_valid) begin
        lg[lidx] <= {cmd_code, cmd_nack, cmd_byte};
        rsp_valid <= 1'b1;
        rsp_nack <= (lidx == n1) || (lidx == n2) || (lidx >= nfrom);
        rsp_byte <= 8'hA0 + lidx[7:0];
        lidx <= lidx + 1;
      end
      if (wr_ready) wptr <= wptr + 1;
      if (rd_valid) begin rbuf[rcnt[3:0]] <= rd_data; rcnt <= rcnt + 1; end
      if (done) begin dseen <= 1; c_chip <= st_chip_nack; c_addr <= st_addr_nack; c_fail <= st_fail_cnt; c_pres <= st_present; end
    end
  end

  task automatic ck(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin bad++; $display("FAIL %s actual=%0h expected=%0h", tag, act, exp); end
  endtask

  task automatic e(input logic [1:0] c, input logic n, input logic [7:0] b);
    ex[ne] = {c, n, b}; ne++;
  endtask

  task automatic chk_seq(input string tag);
    ck(lidx == ne, {tag, " command count"}, lidx, ne);
    for (int i = 0; i < ne && i < lidx; i++)
      ck(lg[i] == ex[i], {tag, " command"}, int'(lg[i]), int'(ex[i]));
  endtask

  task automatic go(input logic [1:0] op, input logic [6:0] chip, input logic [31:0] addr,
                    input logic [2:0] alen, input logic [15:0] len, input logic ovf);
    @(negedge clk) clr = 1;
    @(negedge clk) clr = 0;
    req_op = op; req_chip = chip; req_addr = addr; req_alen = alen; req_len = len; req_ovf = ovf;
    req_valid = 1;
    @(negedge clk) req_valid = 0;
    for (int t = 0; t < 5000 && !dseen; t++) @(negedge clk);
    ne = 0;
  endtask

  task automatic t_write;
    go(0, 7'h50, 32'h1234, 2, 3, 0);
    e(0,0,0); e(2,0,8'hA0); e(2,0,8'h12); e(2,0,8'h34); e(2,0,8'h30); e(2,0,8'h31); e(2,0,8'h32); e(1,0,0);
    chk_seq("R1 R3 write");
    ck(!c_chip && !c_addr && c_fail == 0, "R1 clean status", {c_chip, c_addr, c_fail}, 0);
  endtask

  task automatic t_data_nack;
    n1 = 4; n2 = 6;
    go(0, 7'h50, 32'h1234, 2, 3, 0);
    e(0,0,0); e(2,0,8'hA0); e(2,0,8'h12); e(2,0,8'h34); e(2,0,8'h30); e(2,0,8'h31); e(2,0,8'h32); e(1,0,0);
    chk_seq("R8 data nack continues");
    ck(c_fail == 2, "R8 fail count", c_fail, 2);
    n1 = -1; n2 = -1;
  endtask

  task automatic t_chip_nack;
    n1 = 1;
    go(0, 7'h50, 32'h1234, 2, 3, 0);
    e(0,0,0); e(2,0,8'hA0); e(1,0,0);
    chk_seq("R2 chip nack");
    ck(c_chip && !c_addr, "R2 chip flag", {c_chip, c_addr}, 2);
    n1 = -1;
  endtask

  task automatic t_addr_nack;
    n1 = 2;
    go(0, 7'h50, 32'h1234, 2, 3, 0);
    e(0,0,0); e(2,0,8'hA0); e(2,0,8'h12); e(1,0,0);
    chk_seq("R4 addr nack");
    ck(!c_chip && c_addr, "R4 addr flag", {c_chip, c_addr}, 1);
    n1 = -1;
  endtask

  task automatic t_read;
    go(1, 7'h50, 32'h07, 1, 3, 0);
    e(0,0,0); e(2,0,8'hA0); e(2,0,8'h07); e(1,0,0); e(0,0,0); e(2,0,8'hA1);
    e(3,0,0); e(3,0,0); e(3,1,0); e(1,0,0);
    chk_seq("R5 R7 read");
    ck(rcnt == 3, "R7 byte count", rcnt, 3);
    for (int i = 0; i < 3; i++) ck(rbuf[i] == 8'hA6 + 8'(i), "R7 read data", rbuf[i], 8'hA6 + i);
  endtask

  task automatic t_read_noaddr;
    go(1, 7'h50, 32'hFF, 0, 2, 0);
    e(0,0,0); e(2,0,8'hA1); e(3,0,0); e(3,1,0); e(1,0,0);
    chk_seq("R6 read no address");
    ck(rbuf[0] == 8'hA2 && rbuf[1] == 8'hA3, "R6 read data", {rbuf[0], rbuf[1]}, 16'hA2A3);
  endtask

  task automatic t_read_zero;
    go(1, 7'h50, 32'h10, 1, 0, 0);
    e(0,0,0); e(2,0,8'hA0); e(2,0,8'h10); e(1,0,0); e(0,0,0); e(2,0,8'hA1); e(1,0,0);
    chk_seq("R11 zero-length read");
    ck(rcnt == 0, "R11 no bytes", rcnt, 0);
  endtask

  task automatic t_probe(input bit absent);
    if (absent) n1 = 1;
    go(2, 7'h21, 32'h0, 2, 4, 0);
    e(0,0,0); e(2,0,8'h43); e(1,0,0);
    chk_seq("R10 probe");
    ck(c_pres == !absent, "R10 present flag", c_pres, !absent);
    n1 = -1;
  endtask

  task automatic t_fold;
    go(1, 7'h50, 32'h305, 1, 1, 1);
    e(0,0,0); e(2,0,8'hA6); e(2,0,8'h05); e(1,0,0); e(0,0,0); e(2,0,8'hA7); e(3,1,0); e(1,0,0);
    chk_seq("R9 overflow fold");
  endtask

  task automatic t_wide_addr;
    go(0, 7'h50, 32'hDEADBEEF, 4, 0, 0);
    e(0,0,0); e(2,0,8'hA0); e(2,0,8'hDE); e(2,0,8'hAD); e(2,0,8'hBE); e(2,0,8'hEF); e(1,0,0);
    chk_seq("R3 four address bytes");
  endtask

  task automatic t_saturate;
    nfrom = 2;
    go(0, 7'h50, 32'h0, 0, 300, 0);
    ck(lidx == 303, "R8 all bytes sent", lidx, 303);
    ck(c_fail == 8'hFF, "R8 saturation", c_fail, 255);
    nfrom = 100000;
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    ck(req_ready && !cmd_valid && !done, "R12 reset idle", {req_ready, cmd_valid, done}, 4);
    t_write();
    t_data_nack();
    t_chip_nack();
    t_addr_nack();
    t_read();
    t_read_noaddr();
    t_read_zero();
    t_probe(0);
    t_probe(1);
    t_fold();
    t_wide_addr();
    t_saturate();
    @(negedge clk);
    ck(req_ready && !cmd_valid, "R12 idle after requests", {req_ready, cmd_valid}, 2);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule